// File: doc/BRIEF.md
# Zero-Crossing Selection Calibration Engine

This controller runs the fine calibration of a redundantly built folding converter once the coarse quantizer's transition levels are known. For every output code, in order from the lowest to the highest, it drives a search DAC around the code's ideal level. It watches the bank of redundant comparator outputs for one that changes state inside the current window. Each candidate must also change state exactly once across its coarse octant. The octant edges come from the coarse trip levels, which are supplied as inputs. A candidate that passes is recorded for the code, together with a bit that tells the decoder whether to invert its output.

The search window starts one DAC step either side of the ideal level. It widens by one step whenever no usable candidate appears or the only candidate fails the octant check. Any comparator may end up serving any code, and each is used at most once. When the last code has been written, the power-enable vector keeps only the chosen comparators on, and it also gates their clocks. A folder is kept on while at least one of its two comparators is on.

Top module: `fzc_cal_engine`

## Requirements
- R1: Out of reset the engine is idle: `done` is low, `mem_we` is low, and every bit of `comp_en` and `folder_en` is high.
- R2: A calibration run writes exactly one entry per code, for codes 1 up to 2^CODE_W-1 in ascending order, with `mem_addr` equal to the code.
- R3: The ideal level of a code is the code shifted left by DAC_W-CODE_W. The window for half-width d spans ideal-d (clamped to 0) up to ideal+d (clamped to the DAC maximum). d starts at 1 for each code and grows by 1 after each failed attempt.
- R4: A candidate is a comparator whose output differs between the two window edges, that no earlier code has taken, and that has not been rejected for the current code. The lowest-index candidate is tried.
- R5: The candidate is accepted only when sweeping the DAC in single steps over the whole octant of the code's ideal level shows exactly one change of its output.
- R6: The octant of a level equals the number of coarse trip entries less than or equal to it. Octant k spans from trip k-1 (0 when k is 0) to trip k minus 1 (the DAC maximum for the top octant). Trip entry k sits at bits [k*DAC_W +: DAC_W] of `coarse_trip`, and the entries ascend.
- R7: A candidate that fails the octant check is excluded for the rest of that code, and the window widens.
- R8: The inversion bit of an accepted entry equals the candidate's output at the lower window edge: 1 means the output falls as the level rises.
- R9: The entry is {valid (MSB), comparator index (IDX_W bits), octant (OCT_W bits), inversion (bit 0)}. When an attempt fails at d = MAX_DELTA, the engine writes valid=0, index 0, inversion 0, with the octant field still filled, and moves on.
- R10: After the last write, `done` is high. `comp_en` then holds exactly the accepted comparators, and bit f of `folder_en` is the OR of `comp_en` bits 2f and 2f+1.
- R11: A `start` pulse while a run is in progress has no effect on the entries written or on their order.
- R12: A `start` pulse while `done` is high begins a new run: `done` drops, all enables return high, and all previous selections are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (idle or finished only) |
| comp_out | input | NCOMP | Redundant comparator decisions for the present DAC level |
| coarse_trip | input | (2^OCT_W-1)*DAC_W | Ascending coarse transition levels |
| dac_code | output | DAC_W | Search DAC level |
| mem_we | output | 1 | Selection memory write strobe |
| mem_addr | output | CODE_W | Code being written |
| mem_wdata | output | IDX_W+OCT_W+2 | Selection entry |
| done | output | 1 | Calibration complete |
| comp_en | output | NCOMP | Comparator power and clock enable |
| folder_en | output | NCOMP/2 | Folder power enable |

## Verification
The bench builds the engine with CODE_W=5, DAC_W=7, NCOMP=32, OCT_W=3 and MAX_DELTA=6. With these values each code is four DAC steps apart, and each octant sweep takes about sixteen steps, so two complete runs are short. The small MAX_DELTA makes the give-up path reachable, because two comparators with no crossing at all are placed next to each other. The comparator model adds a spare low-index comparator that takes over a code, several outputs that fall as the level rises, and outputs with a second crossing inside their own octant. These force octant rejection and reassignment to a different code.

// File: rtl/fzc_pkg.sv
package fzc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CAP_LO,
    S_CAP_HI,
    S_SW_FIRST,
    S_SWEEP,
    S_JUDGE,
    S_FINISH
  } cal_state_t;
endpackage

// File: rtl/fzc_pick.sv
// Lowest-index selector over the candidate vector.
module fzc_pick #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R4: a reported winner is a requester
  always_comb begin
    if (found) begin
      assert_pick_is_request_R4: assert (req[idx]);
    end
  end
endmodule

// File: rtl/fzc_octant.sv
// Maps a DAC level to its coarse octant and that octant's inclusive edges.
module fzc_octant #(
  parameter int DAC_W = 10,
  parameter int OCT_W = 3,
  localparam int NOCT  = 2 ** OCT_W,
  localparam int NTRIP = NOCT - 1
) (
  input  logic [DAC_W-1:0]       level,
  input  logic [NTRIP*DAC_W-1:0] trips,
  output logic [OCT_W-1:0]       oct,
  output logic [DAC_W-1:0]       edge_lo,
  output logic [DAC_W-1:0]       edge_hi
);
  logic [DAC_W-1:0] tp     [NTRIP];
  logic [DAC_W-1:0] lo_tab [NOCT];
  logic [DAC_W-1:0] hi_tab [NOCT];

  for (genvar k = 0; k < NTRIP; k++) begin : g_unpack
    assign tp[k] = trips[k*DAC_W +: DAC_W];
  end

  for (genvar k = 0; k < NOCT; k++) begin : g_edges
    if (k == 0) begin : g_first
      assign lo_tab[k] = '0;
    end else begin : g_rest
      assign lo_tab[k] = tp[k-1];
    end
    if (k == NOCT - 1) begin : g_top
      assign hi_tab[k] = '1;
    end else begin : g_below
      assign hi_tab[k] = tp[k] - 1'b1;
    end
  end

  always_comb begin
    oct = '0;
    for (int k = 0; k < NTRIP; k++) begin
      if (tp[k] <= level) oct = oct + 1'b1;
    end
  end

  assign edge_lo = lo_tab[oct];
  assign edge_hi = hi_tab[oct];
endmodule

// File: rtl/fzc_cal_engine.sv
module fzc_cal_engine #(
  parameter int CODE_W    = 8,
  parameter int DAC_W     = 10,
  parameter int NCOMP     = 256,
  parameter int OCT_W     = 3,
  parameter int MAX_DELTA = 32,
  localparam int IDX_W   = $clog2(NCOMP),
  localparam int ENTRY_W = IDX_W + OCT_W + 2,
  localparam int NTRIP   = 2 ** OCT_W - 1,
  localparam int NFOLD   = NCOMP / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NCOMP-1:0]       comp_out,
  input  logic [NTRIP*DAC_W-1:0] coarse_trip,
  output logic [DAC_W-1:0]       dac_code,
  output logic                   mem_we,
  output logic [CODE_W-1:0]      mem_addr,
  output logic [ENTRY_W-1:0]     mem_wdata,
  output logic                   done,
  output logic [NCOMP-1:0]       comp_en,
  output logic [NFOLD-1:0]       folder_en
);
  import fzc_pkg::*;

  localparam int NCODE = 2 ** CODE_W - 1;
  localparam int SH    = DAC_W - CODE_W;
  localparam int DEL_W = $clog2(MAX_DELTA + 1);

  function automatic logic [DAC_W-1:0] ideal_of(input logic [CODE_W-1:0] c);
    return DAC_W'(c) << SH;
  endfunction

  function automatic logic [DAC_W-1:0] win_lo(input logic [DAC_W-1:0] c,
                                              input logic [DEL_W-1:0] d);
    return (c > DAC_W'(d)) ? c - DAC_W'(d) : '0;
  endfunction

  function automatic logic [DAC_W-1:0] win_hi(input logic [DAC_W-1:0] c,
                                              input logic [DEL_W-1:0] d);
    logic [DAC_W:0] s;
    s = {1'b0, c} + (DAC_W + 1)'(d);
    return s[DAC_W] ? '1 : s[DAC_W-1:0];
  endfunction

  cal_state_t        state;
  logic [CODE_W-1:0] code;
  logic [DEL_W-1:0]  delta;
  logic [NCOMP-1:0]  used, rejected, snap_lo;
  logic [IDX_W-1:0]  cand_idx;
  logic              cand_pol, prev_bit;
  logic [1:0]        toggles;

  // named internal events
  logic [DAC_W-1:0]  ideal, edge_lo, edge_hi;
  logic [OCT_W-1:0]  oct;
  logic [NCOMP-1:0]  cand_req;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              cur_bit, at_max, last_code, sweep_end, start_ok;
  logic              ev_miss, ev_accept, ev_reject, ev_giveup, ev_widen, ev_write;

  assign ideal = ideal_of(code);

  fzc_octant #(.DAC_W(DAC_W), .OCT_W(OCT_W)) u_oct (
    .level(ideal), .trips(coarse_trip), .oct(oct),
    .edge_lo(edge_lo), .edge_hi(edge_hi)
  );

  assign cand_req = (snap_lo ^ comp_out) & ~used & ~rejected;

  fzc_pick #(.N(NCOMP)) u_pick (.req(cand_req), .found(pick_found), .idx(pick_idx));

  assign cur_bit   = comp_out[cand_idx];
  assign at_max    = (delta == DEL_W'(MAX_DELTA));
  assign last_code = (code == CODE_W'(NCODE));
  assign sweep_end = (dac_code == edge_hi);
  assign start_ok  = start && (state == S_IDLE || state == S_FINISH);
  assign ev_miss   = (state == S_CAP_HI) && !pick_found;
  assign ev_accept = (state == S_JUDGE) && (toggles == 2'd1);
  assign ev_reject = (state == S_JUDGE) && (toggles != 2'd1);
  assign ev_giveup = (ev_miss || ev_reject) && at_max;
  assign ev_widen  = (ev_miss || ev_reject) && !at_max;
  assign ev_write  = ev_accept || ev_giveup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      code      <= '0;
      delta     <= '0;
      used      <= '0;
      rejected  <= '0;
      snap_lo   <= '0;
      cand_idx  <= '0;
      cand_pol  <= 1'b0;
      prev_bit  <= 1'b0;
      toggles   <= '0;
      dac_code  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state)
        S_IDLE, S_FINISH: begin
          if (start_ok) begin
            state    <= S_CAP_LO;
            code     <= CODE_W'(1);
            delta    <= DEL_W'(1);
            used     <= '0;
            rejected <= '0;
            dac_code <= win_lo(ideal_of(CODE_W'(1)), DEL_W'(1));
          end
        end
        S_CAP_LO: begin
          snap_lo  <= comp_out;
          dac_code <= win_hi(ideal, delta);
          state    <= S_CAP_HI;
        end
        S_CAP_HI: begin
          if (pick_found) begin
            cand_idx <= pick_idx;
            cand_pol <= snap_lo[pick_idx];
            dac_code <= edge_lo;
            state    <= S_SW_FIRST;
          end
        end
        S_SW_FIRST, S_SWEEP: begin
          if (state == S_SW_FIRST) toggles <= '0;
          else if (cur_bit != prev_bit && toggles != 2'd2) toggles <= toggles + 1'b1;
          prev_bit <= cur_bit;
          if (sweep_end) state <= S_JUDGE;
          else begin
            dac_code <= dac_code + 1'b1;
            state    <= S_SWEEP;
          end
        end
        S_JUDGE: begin
          if (ev_reject) rejected[cand_idx] <= 1'b1;
          if (ev_accept) used[cand_idx]     <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase

      if (ev_widen) begin
        delta    <= delta + 1'b1;
        dac_code <= win_lo(ideal, delta + 1'b1);
        state    <= S_CAP_LO;
      end

      if (ev_write) begin
        mem_we    <= 1'b1;
        mem_addr  <= code;
        mem_wdata <= {ev_accept, (ev_accept ? cand_idx : IDX_W'(0)), oct,
                      (ev_accept & cand_pol)};
        if (last_code) begin
          state <= S_FINISH;
        end else begin
          code     <= code + 1'b1;
          delta    <= DEL_W'(1);
          rejected <= '0;
          dac_code <= win_lo(ideal_of(code + 1'b1), DEL_W'(1));
          state    <= S_CAP_LO;
        end
      end
    end
  end

  assign done    = (state == S_FINISH);
  assign comp_en = done ? used : '1;

  for (genvar f = 0; f < NFOLD; f++) begin : g_folder
    assign folder_en[f] = comp_en[2*f] | comp_en[2*f+1];
  end

  // ---------------- assertions ----------------
  logic [CODE_W-1:0] wr_prev;
  logic [IDX_W:0]    valid_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || start_ok) begin
      wr_prev   <= '0;
      valid_cnt <= '0;
    end else if (mem_we) begin
      wr_prev   <= mem_addr;
      valid_cnt <= valid_cnt + (IDX_W + 1)'(mem_wdata[ENTRY_W-1]);
    end
  end

  assert_write_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == CODE_W'(wr_prev + 1'b1)));

  assert_delta_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_FINISH) |->
      (delta >= DEL_W'(1) && delta <= DEL_W'(MAX_DELTA)));

  assert_no_reuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !used[cand_idx]);

  assert_sweep_in_octant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWEEP) |-> (dac_code >= edge_lo && dac_code <= edge_hi));

  assert_power_matches_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |->
      ($countones(comp_en) == int'(valid_cnt) + int'(mem_we & mem_wdata[ENTRY_W-1])));
endmodule

// File: tb/tb_fzc_cal_engine.sv
module tb_fzc_cal_engine;
  localparam int CODE_W = 5, DAC_W = 7, NCOMP = 32, OCT_W = 3, MAX_DELTA = 6;
  localparam int NCODE = 2 ** CODE_W - 1, NTRIP = 2 ** OCT_W - 1;
  localparam int IDX_W = $clog2(NCOMP), EW = IDX_W + OCT_W + 2, NFOLD = NCOMP / 2;
  localparam int DMAX = 2 ** DAC_W - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NCOMP-1:0]       comp_out;
  logic [NTRIP*DAC_W-1:0] coarse_trip;
  logic [DAC_W-1:0]       dac_code;
  logic                   mem_we, done;
  logic [CODE_W-1:0]      mem_addr;
  logic [EW-1:0]          mem_wdata;
  logic [NCOMP-1:0]       comp_en;
  logic [NFOLD-1:0]       folder_en;

  int n_checks = 0, n_fail = 0, n_writes = 0, obs_invalid = 0, obs_inverted = 0;

  always #2.5 clk = ~clk;

  fzc_cal_engine #(.CODE_W(CODE_W), .DAC_W(DAC_W), .NCOMP(NCOMP), .OCT_W(OCT_W),
                   .MAX_DELTA(MAX_DELTA)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .comp_out(comp_out),
    .coarse_trip(coarse_trip), .dac_code(dac_code), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
    .comp_en(comp_en), .folder_en(folder_en));

  // ---------- analog front-end model ----------
  function automatic int trip_lv(int k);
    case (k)
      0: return 15; 1: return 33; 2: return 48; 3: return 63;
      4: return 81; 5: return 96; default: return 111;
    endcase
  endfunction

  function automatic int t1(int i);
    if (i == 0) return 70;
    if (i == 20 || i == 21) return 200;
    return 4 * i + (i % 5) - 2;
  endfunction

  function automatic int t2(int i);
    return (i % 7 == 3) ? t1(i) + 3 : 200;
  endfunction

  function automatic bit model(int i, int lv);
    return ((lv >= t1(i)) ^ (lv >= t2(i))) ^ (i % 3 == 1);
  endfunction

  function automatic int oct_of(int lv);
    int o = 0;
    for (int k = 0; k < NTRIP; k++) if (trip_lv(k) <= lv) o++;
    return o;
  endfunction

  always_comb begin
    for (int k = 0; k < NTRIP; k++) coarse_trip[k*DAC_W +: DAC_W] = DAC_W'(trip_lv(k));
    for (int i = 0; i < NCOMP; i++) comp_out[i] = model(i, int'(dac_code));
  end

  // ---------- scoreboard ----------
  logic [CODE_W+EW-1:0] exp_q[$];
  logic [NCOMP-1:0]     exp_used;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_expected();
    exp_q.delete();
    exp_used = '0;
    for (int c = 1; c <= NCODE; c++) begin
      int ideal = c * (2 ** (DAC_W - CODE_W));
      int o = oct_of(ideal);
      int elo = (o == 0) ? 0 : trip_lv(o - 1);
      int ehi = (o == NTRIP) ? DMAX : trip_lv(o) - 1;
      logic [NCOMP-1:0] rej = '0;
      bit fin = 0;
      int d = 1;
      while (!fin) begin
        int lo = (ideal > d) ? ideal - d : 0;
        int hi = (ideal + d > DMAX) ? DMAX : ideal + d;
        int pk = -1;
        bit ok = 0;
        for (int i = 0; i < NCOMP; i++) begin
          if (!exp_used[i] && !rej[i] && model(i, lo) != model(i, hi)) begin
            pk = i;
            break;
          end
        end
        if (pk >= 0) begin
          int tg = 0;
          for (int v = elo + 1; v <= ehi; v++) if (model(pk, v) != model(pk, v - 1)) tg++;
          ok = (tg == 1);
          if (!ok) rej[pk] = 1'b1;
        end
        if (ok) begin
          exp_q.push_back({CODE_W'(c), 1'b1, IDX_W'(pk), OCT_W'(o), model(pk, lo)});
          exp_used[pk] = 1'b1;
          fin = 1;
        end else if (d == MAX_DELTA) begin
          exp_q.push_back({CODE_W'(c), 1'b0, IDX_W'(0), OCT_W'(o), 1'b0});
          fin = 1;
        end else begin
          d++;
        end
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      logic [CODE_W+EW-1:0] e;
      n_writes++;
      if (mem_wdata[EW-1] == 1'b0) obs_invalid++;
      if (mem_wdata[EW-1] && mem_wdata[0]) obs_inverted++;
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected write", int'(mem_addr), -1);
      end else begin
        e = exp_q.pop_front();
        check(mem_addr == e[CODE_W+EW-1:EW], "R2 code order", int'(mem_addr),
              int'(e[CODE_W+EW-1:EW]));
        check(mem_wdata[EW-1] == e[EW-1], "R5/R7 valid bit", int'(mem_wdata[EW-1]),
              int'(e[EW-1]));
        check(mem_wdata[EW-2:OCT_W+1] == e[EW-2:OCT_W+1], "R3/R4 comparator index",
              int'(mem_wdata[EW-2:OCT_W+1]), int'(e[EW-2:OCT_W+1]));
        check(mem_wdata[OCT_W:1] == e[OCT_W:1], "R6 octant", int'(mem_wdata[OCT_W:1]),
              int'(e[OCT_W:1]));
        check(mem_wdata[0] == e[0], "R8 inversion bit", int'(mem_wdata[0]), int'(e[0]));
        if (!e[EW-1]) check(mem_wdata == e[EW-1:0], "R9 give-up entry", int'(mem_wdata),
                            int'(e[EW-1:0]));
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done_and_check(int runs);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b1, "R10 done high", int'(done), 1);
    check(n_writes == runs * NCODE, "R2 write count", n_writes, runs * NCODE);
    check(exp_q.size() == 0, "R2 all entries seen", exp_q.size(), 0);
    check(comp_en == exp_used, "R10 comparator enables", int'(comp_en), int'(exp_used));
    for (int f = 0; f < NFOLD; f++)
      check(folder_en[f] == (exp_used[2*f] | exp_used[2*f+1]), "R10 folder enable",
            int'(folder_en[f]), int'(exp_used[2*f] | exp_used[2*f+1]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(mem_we == 1'b0, "R1 no write after reset", int'(mem_we), 0);
    check(&comp_en, "R1 comparators on", int'(comp_en), -1);
    check(&folder_en, "R1 folders on", int'(folder_en), -1);

    build_expected();
    pulse_start();
    repeat (40) @(negedge clk);
    // R11: mid-run start must change nothing the scoreboard sees
    check(done == 1'b0, "R11 still running", int'(done), 0);
    pulse_start();
    wait_done_and_check(1);
    check(obs_invalid > 0, "R9 give-up entry seen", obs_invalid, 1);
    check(obs_inverted > 0, "R8 inverted entry seen", obs_inverted, 1);

    // R12: restart from finished
    build_expected();
    pulse_start();
    check(done == 1'b0, "R12 done cleared", int'(done), 0);
    check(&comp_en, "R12 enables restored", int'(comp_en), -1);
    wait_done_and_check(2);
    finish_run();
  end
endmodule